// File: doc/BRIEF.md
# Vernier Phase Snapshot Fine Encoder

This block turns a 140-bit snapshot of delayed clock phases, latched when a hit arrives, into an 8-bit fine time code. The phases come from a vernier array made of four delay loops with 35 taps each. Their raw bit order is scrambled, so the block first routes every raw bit to its position in time through a permutation that is fixed when the design is built. It then removes single-bit bubbles with a three-input majority vote and finds the position of the one-to-zero edge. The position is the number of leading ones.

A hit time is formed downstream as the coarse count times the reference period plus the fine code times the bin width. One reference period spans 140 bins, about 71 ps each at 100 MHz. The block has two register stages. The first stage holds the reordered and corrected vector. The second holds the code and an error flag. The latency is therefore a fixed two cycles, and a new snapshot can be accepted on every cycle.

Top module: `phase_therm_encoder`

## Requirements
- R1: Raw bit 35*j+i, for loop j in 0..3 and tap i in 0..34, is placed at ordered position (4*i+35*j) mod 140. Position 0 is the earliest phase. The mapping covers all 140 positions exactly once.
- R2: The code is the number of consecutive ones in the corrected ordered vector, counted upward from position 0. It lies in 0..139. A vector that is all ones gives 139.
- R3: Before the search, each ordered bit is replaced by the majority of itself and its two neighbours. A one is assumed below position 0 and a zero above position 139.
- R4: The error flag is high with a result when the corrected vector has a zero at some position p and a one at p+1.
- R5: A snapshot sampled with in_valid at clock edge N produces out_valid high for exactly one cycle, starting at edge N+2.
- R6: While out_valid is low, code keeps its last value and err is low.
- R7: While rst_n is low, out_valid, code and err are zero.
- R8: Snapshots presented on consecutive cycles each produce their own result, in the same order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_phase | input | 140 | Raw phase snapshot, bit order scrambled |
| in_valid | input | 1 | Marks raw_phase as valid in this cycle |
| code | output | 8 | Fine code, 0..139 |
| out_valid | output | 1 | Marks code and err as valid |
| err | output | 1 | More than one edge remains after correction |

## Verification
The bench places every one of the 141 thermometer lengths through the scrambled order. A wrong table entry moves the edge or leaves a hole, which shows up as a wrong count or a false error. Bubbles are placed next to the edge, far from it, and at both ends of the vector. A majority vote with the wrong boundary value, or no vote at all, then gives a shifted code or a spurious error. The all-ones case shows whether the count saturates or wraps to a value above 139. Back-to-back snapshots and idle cycles with changing inputs expose an off-by-one in the pipeline, a code that drifts while out_valid is low, and an err flag that stays high.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
    localparam int unsigned TPE_LOOPS = 4;
    localparam int unsigned TPE_TAPS  = 35;

    // position in time of raw tap i of loop j
    function automatic int unsigned dest_index(input int unsigned j, input int unsigned i,
                                               input int unsigned taps, input int unsigned nph);
        return ((nph / taps) * i + taps * j) % nph;
    endfunction
endpackage

// File: rtl/tpe_reorder.sv
module tpe_reorder #(
    parameter int unsigned LOOPS = tpe_pkg::TPE_LOOPS,
    parameter int unsigned TAPS  = tpe_pkg::TPE_TAPS,
    localparam int unsigned NPH  = LOOPS * TAPS
) (
    input  logic [NPH-1:0] raw_i,
    output logic [NPH-1:0] ord_o
);
    for (genvar j = 0; j < LOOPS; j++) begin : g_loop
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            localparam int unsigned SRC = j * TAPS + i;
            localparam int unsigned DST = tpe_pkg::dest_index(j, i, TAPS, NPH);
            assign ord_o[DST] = raw_i[SRC];
        end
    end
endmodule

// File: rtl/tpe_bubble_fix.sv
module tpe_bubble_fix #(
    parameter int unsigned NPH = 140
) (
    input  logic [NPH-1:0] vec_i,
    output logic [NPH-1:0] vec_o
);
    for (genvar p = 0; p < NPH; p++) begin : g_bit
        logic lo, hi;
        if (p == 0) begin : g_bot
            assign lo = 1'b1;
        end else begin : g_lo
            assign lo = vec_i[p-1];
        end
        if (p == NPH - 1) begin : g_top
            assign hi = 1'b0;
        end else begin : g_hi
            assign hi = vec_i[p+1];
        end
        assign vec_o[p] = (lo & vec_i[p]) | (lo & hi) | (vec_i[p] & hi);
    end
endmodule

// File: rtl/tpe_locate.sv
module tpe_locate #(
    parameter int unsigned NPH = 140,
    localparam int unsigned CW = $clog2(NPH)
) (
    input  logic [NPH-1:0] vec_i,
    output logic [CW-1:0]  code_o,
    output logic           err_o
);
    always_comb begin
        logic found;
        found  = 1'b0;
        code_o = CW'(NPH - 1);
        for (int p = 0; p < NPH; p++) begin
            if (!found && !vec_i[p]) begin
                code_o = CW'(p);
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        err_o = 1'b0;
        for (int p = 0; p < NPH - 1; p++) begin
            if (!vec_i[p] && vec_i[p+1]) err_o = 1'b1;
        end
    end
endmodule

// File: rtl/phase_therm_encoder.sv
module phase_therm_encoder #(
    parameter int unsigned LOOPS = tpe_pkg::TPE_LOOPS,
    parameter int unsigned TAPS  = tpe_pkg::TPE_TAPS,
    localparam int unsigned NPH  = LOOPS * TAPS,
    localparam int unsigned CW   = $clog2(NPH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [139:0]   raw_phase,
    input  logic           in_valid,
    output logic [7:0]     code,
    output logic           out_valid,
    output logic           err
);
    typedef struct packed {
        logic           s1_v;
        logic [NPH-1:0] s1_vec;
        logic           s2_v;
        logic [CW-1:0]  s2_code;
        logic           s2_err;
    } pipe_t;

    pipe_t st_d, st_q;
    logic [NPH-1:0] ord_w, fix_w;
    logic [CW-1:0]  loc_code_w;
    logic           loc_err_w;

    tpe_reorder #(.LOOPS(LOOPS), .TAPS(TAPS)) u_reorder (
        .raw_i (raw_phase[NPH-1:0]),
        .ord_o (ord_w)
    );

    tpe_bubble_fix #(.NPH(NPH)) u_fix (
        .vec_i (ord_w),
        .vec_o (fix_w)
    );

    tpe_locate #(.NPH(NPH)) u_locate (
        .vec_i  (st_q.s1_vec),
        .code_o (loc_code_w),
        .err_o  (loc_err_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.s1_v = in_valid;
        if (in_valid) st_d.s1_vec = fix_w;
        st_d.s2_v   = st_q.s1_v;
        st_d.s2_err = 1'b0;
        if (st_q.s1_v) begin
            st_d.s2_code = loc_code_w;
            st_d.s2_err  = loc_err_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code      = 8'(st_q.s2_code);
    assign out_valid = st_q.s2_v;
    assign err       = st_q.s2_err;

    AST_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ##1 out_valid);           // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid, 2));   // R5
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (code < 8'(NPH)));       // R2
    AST_CODE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(code));        // R6
    AST_ERR_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> !err);                 // R6
endmodule

// File: tb/phase_therm_encoder_bench.sv
`timescale 1ns/1ps
module phase_therm_encoder_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [139:0] raw_phase = '0;
    logic         in_valid = 1'b0;
    logic [7:0]   code;
    logic         out_valid, err;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    phase_therm_encoder u_phase_therm_encoder (
        .clk(clk), .rst_n(rst_n), .raw_phase(raw_phase), .in_valid(in_valid),
        .code(code), .out_valid(out_valid), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [139:0] therm(input int k);
        logic [139:0] v;
        for (int p = 0; p < 140; p++) v[p] = (p < k);
        return v;
    endfunction

    // R1: scramble an ordered vector into raw tap order
    function automatic logic [139:0] to_raw(input logic [139:0] ord);
        logic [139:0] r;
        for (int j = 0; j < 4; j++)
            for (int i = 0; i < 35; i++)
                r[35*j+i] = ord[(4*i + 35*j) % 140];
        return r;
    endfunction

    // R3: majority with one below and zero above
    function automatic logic [139:0] fix(input logic [139:0] v);
        logic [139:0] f;
        for (int p = 0; p < 140; p++) begin
            int s;
            s = int'(v[p]) + ((p == 0) ? 1 : int'(v[p-1])) + ((p == 139) ? 0 : int'(v[p+1]));
            f[p] = (s >= 2);
        end
        return f;
    endfunction

    function automatic int ref_code(input logic [139:0] ord);
        logic [139:0] f;
        f = fix(ord);
        for (int p = 0; p < 140; p++) if (!f[p]) return p;
        return 139;
    endfunction

    function automatic bit ref_err(input logic [139:0] ord);
        logic [139:0] f;
        f = fix(ord);
        for (int p = 0; p < 139; p++) if (!f[p] && f[p+1]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic run_one(input logic [139:0] ord, input string req);
        int ec; bit ee;
        ec = ref_code(ord); ee = ref_err(ord);
        @(negedge clk); raw_phase = to_raw(ord); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0; raw_phase = ~raw_phase;
        chk(out_valid == 1'b0, "R5 early valid", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R5 valid", int'(out_valid), 1);
        chk(int'(code) == ec, {req, " code"}, int'(code), ec);
        chk(err == ee, {req, " err"}, int'(err), int'(ee));
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 single pulse", int'(out_valid), 0);
        chk(int'(code) == ec, "R6 hold", int'(code), ec);
        chk(err == 1'b0, "R6 err low", int'(err), 0);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R7 valid", int'(out_valid), 0);
        chk(code == 8'd0, "R7 code", int'(code), 0);
        chk(err == 1'b0, "R7 err", int'(err), 0);
    endtask

    task automatic t_sweep();
        for (int k = 0; k <= 140; k++) run_one(therm(k), "R1 R2 sweep");
    endtask

    task automatic t_bubbles();
        logic [139:0] v;
        int ks[3] = '{10, 70, 130};
        foreach (ks[n]) begin
            v = therm(ks[n]); v[ks[n]-4] = 1'b0; run_one(v, "R3 hole");
            v = therm(ks[n]); v[ks[n]+4] = 1'b1; run_one(v, "R3 spike");
            v = therm(ks[n]); v[ks[n]-1] = 1'b0; run_one(v, "R3 edge hole");
        end
        v = therm(140); v[0] = 1'b0;   run_one(v, "R3 bottom end");
        v = therm(0);   v[139] = 1'b1; run_one(v, "R3 top end");
        v = therm(50);  v[0] = 1'b0;   run_one(v, "R3 bottom in");
    endtask

    task automatic t_multi();
        logic [139:0] v;
        v = therm(20) | (therm(100) & ~therm(60));
        run_one(v, "R4 two runs");
        chk(ref_err(v) == 1'b1, "R4 model", int'(ref_err(v)), 1);
        v = therm(5) | (therm(9) & ~therm(7));
        run_one(v, "R4 near runs");
        run_one(therm(33), "R4 clean after");
    endtask

    task automatic t_hold();
        run_one(therm(77), "R6 setup");
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); raw_phase = to_raw(therm(c * 30 + 3)); in_valid = 1'b0;
            chk(out_valid == 1'b0, "R6 idle valid", int'(out_valid), 0);
            chk(code == 8'd77, "R6 idle code", int'(code), 77);
            chk(err == 1'b0, "R6 idle err", int'(err), 0);
        end
    endtask

    task automatic t_stream();
        logic [139:0] a, b, c;
        a = therm(12); b = therm(12) | (therm(90) & ~therm(40)); c = therm(139);
        @(negedge clk); raw_phase = to_raw(a); in_valid = 1'b1;
        @(negedge clk); raw_phase = to_raw(b);
        @(negedge clk); raw_phase = to_raw(c);
        chk(out_valid && code == 8'd12 && !err, "R8 first", int'(code), 12);
        @(negedge clk); in_valid = 1'b0;
        chk(out_valid && int'(code) == ref_code(b) && err, "R8 second", int'(code), ref_code(b));
        @(negedge clk);
        chk(out_valid && code == 8'd139 && !err, "R8 third", int'(code), 139);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 end", int'(out_valid), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_bubbles();
        t_multi();
        t_hold();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule